// File: doc/BRIEF.md
# Flat panel output blanking control

This block sits between the pixel pipeline and the pins of a flat panel. On every pixel clock it registers the panel data bus, the display-enable strobe and the line pulse. It bases them on the horizontal and vertical blank strobes, a line-pulse timing strobe from the timing generator, and the raw 8:8:8 pixel value. All three outputs share a single register stage, so data, enable and line pulse stay aligned.

One 8-bit control register sets the behaviour. It is reached through an index port and a data port on an I/O-style register bus. Its fields are:

- The bus width: 16-bit 5:6:5, 24-bit 8:8:8, or 36-bit, which carries two 6:6:6 pixels per word.
- A flag that drives every data line high during vertical blank.
- Two bits that keep display enable and the line pulse alive during vertical blank. Either bit has this effect.

Single-drive panels that need line pulses through vertical blank use these two bits. Dual-drive panels leave them clear, so each half-frame receives only the visible line count.

Top module: `fp_blank_ctrl`

## Requirements
- R1: After reset the control register reads 00h. Writing a value to the index port (address 3D0h) selects a register. When index 12h is selected, a write to the data port (address 3D1h) stores the value, and a combinational read of the data port returns it unchanged, including bits 2:0.
- R2: A data-port write while any index other than 12h is selected leaves the control register unchanged.
- R3: With width code 00 (control bits 7:6), panel_data[15:0] = {R[7:3], G[7:2], B[7:3]} and panel_data[35:16] = 0.
- R4: With width code 01, panel_data[23:0] = {R, G, B} and panel_data[35:24] = 0.
- R5: The reserved width code 10 produces the same output as code 00.
- R6: With width code 11, the first active pixel after horizontal blank supplies {R[7:2], G[7:2], B[7:2]} to panel_data[17:0]. The pixel after it supplies panel_data[35:18]. The bus is updated only on the second pixel of each pair and holds its value in between.
- R7: When control bit 5 is 1 and vblank is high, all 36 bits of panel_data are 1. Outside vertical blank, bit 5 has no effect.
- R8: When control bit 5 is 0, pixel data passes to the bus during vertical blank as it does during active video.
- R9: When control bits 3 and 4 are both 0 (the reset state), panel_de = NOT(hblank OR vblank).
- R10: When control bit 3 is 1, panel_de = NOT hblank, and panel_lp follows lp_strobe during vertical blank.
- R11: When control bit 4 is 1 and bit 3 is 0, display enable and line pulse behave as in R10.
- R12: When control bits 3 and 4 are both 0, panel_lp is low throughout vertical blank. A frame of 240 active lines followed by vertical-blank lines, with one lp_strobe per line, yields exactly 240 line pulses.
- R13: panel_data, panel_de and panel_lp each reflect their inputs exactly one pixel clock later, and are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Register bus address |
| io_wr | input | 1 | Register bus write strobe |
| io_wdata | input | 8 | Register bus write data |
| io_rdata | output | 8 | Register bus read data, combinational |
| hblank | input | 1 | Horizontal blank |
| vblank | input | 1 | Vertical blank |
| lp_strobe | input | 1 | Line pulse timing from the timing generator |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| panel_data | output | 36 | Formatted panel data bus |
| panel_de | output | 1 | Display enable, active high |
| panel_lp | output | 1 | Line pulse |

## Verification
A corrupted control register appears at the port on the very next clock as a wrong bus packing, lost or extra line pulses in vertical blank, or display enable toggling when it should stay low. A register readback exposes it directly. The 36-bit pair phase is the only state that is not visible by readback. If the phase slips, the two halves of the bus swap on the first pair after horizontal blank, so the error shows two clocks after blank ends. Counting line pulses over a whole frame catches suppression that leaks or misses by even a single line.

// File: rtl/fpb_pkg.sv
`timescale 1ns/1ps
package fpb_pkg;
    localparam int PIX_W  = 8;
    localparam int BUS_W  = 36;
    localparam int HALF_W = BUS_W / 2;
    localparam int REG_W  = 8;

    typedef enum logic [1:0] {
        WID_16  = 2'b00,
        WID_24  = 2'b01,
        WID_RSV = 2'b10,
        WID_36  = 2'b11
    } wid_e;

    typedef struct packed {
        wid_e       wid;
        logic       vb_force_hi;
        logic       vb_lp_keep;
        logic       de_hb_only;
        logic [2:0] spare;
    } ctrl_t;

    typedef struct packed {
        logic [PIX_W-1:0] r;
        logic [PIX_W-1:0] g;
        logic [PIX_W-1:0] b;
    } pix_t;

    function automatic logic [BUS_W-1:0] pack565(input pix_t p);
        logic [BUS_W-1:0] w;
        w = '0;
        w[15:0] = {p.r[PIX_W-1 -: 5], p.g[PIX_W-1 -: 6], p.b[PIX_W-1 -: 5]};
        return w;
    endfunction

    function automatic logic [BUS_W-1:0] pack888(input pix_t p);
        logic [BUS_W-1:0] w;
        w = '0;
        w[3*PIX_W-1:0] = p;
        return w;
    endfunction

    function automatic logic [HALF_W-1:0] pack666(input pix_t p);
        return {p.r[PIX_W-1 -: 6], p.g[PIX_W-1 -: 6], p.b[PIX_W-1 -: 6]};
    endfunction
endpackage

// File: rtl/fpb_regs.sv
`timescale 1ns/1ps
module fpb_regs
    import fpb_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03D0,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03D1,
    parameter logic [REG_W-1:0]  CTRL_IDX = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    output ctrl_t             ctrl
);
    logic [REG_W-1:0] index_q;
    ctrl_t            ctrl_q;
    logic             ctrl_sel;

    assign ctrl_sel = (io_addr == DAT_ADDR) && (index_q == CTRL_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            ctrl_q  <= '0;
        end else if (io_wr) begin
            if (io_addr == IDX_ADDR)
                index_q <= io_wdata;
            else if (ctrl_sel)
                ctrl_q <= ctrl_t'(io_wdata);
        end
    end

    always_comb begin
        if (io_addr == IDX_ADDR)
            io_rdata = index_q;
        else if (ctrl_sel)
            io_rdata = ctrl_q;
        else
            io_rdata = '0;
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/fpb_sync.sv
`timescale 1ns/1ps
module fpb_sync (
    input  logic clk,
    input  logic rst,
    input  logic hblank,
    input  logic vblank,
    input  logic lp_strobe,
    input  logic keep_vb,
    output logic de,
    output logic lp
);
    logic vb_gate;

    assign vb_gate = vblank & ~keep_vb;

    always_ff @(posedge clk) begin
        if (rst) begin
            de <= 1'b0;
            lp <= 1'b0;
        end else begin
            de <= ~hblank & ~vb_gate;
            lp <= lp_strobe & ~vb_gate;
        end
    end
endmodule

// File: rtl/fpb_fmt.sv
`timescale 1ns/1ps
module fpb_fmt
    import fpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  wid_e             wid,
    input  logic             force_hi,
    input  logic             hblank,
    input  logic             vblank,
    input  pix_t             pix,
    output logic [BUS_W-1:0] data
);
    logic              phase_q;
    logic [HALF_W-1:0] hold_q;
    logic              wide;
    logic              force_now;

    assign wide      = (wid == WID_36);
    assign force_now = vblank & force_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            hold_q  <= '0;
            data    <= '0;
        end else begin
            phase_q <= wide & ~hblank & ~phase_q;
            if (wide && !phase_q)
                hold_q <= pack666(pix);
            if (force_now)
                data <= '1;
            else begin
                unique case (wid)
                    WID_24: data <= pack888(pix);
                    WID_36: if (phase_q) data <= {pack666(pix), hold_q};
                    default: data <= pack565(pix);
                endcase
            end
        end
    end
endmodule

// File: rtl/fp_blank_ctrl.sv
`timescale 1ns/1ps
module fp_blank_ctrl
    import fpb_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h03D0,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h03D1,
    parameter logic [REG_W-1:0]  CTRL_IDX = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [REG_W-1:0]  io_wdata,
    output logic [REG_W-1:0]  io_rdata,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              lp_strobe,
    input  logic [PIX_W-1:0]  pix_r,
    input  logic [PIX_W-1:0]  pix_g,
    input  logic [PIX_W-1:0]  pix_b,
    output logic [BUS_W-1:0]  panel_data,
    output logic              panel_de,
    output logic              panel_lp
);
    ctrl_t ctrl_q;
    pix_t  pix;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b};

    fpb_regs #(
        .ADDR_W  (ADDR_W),
        .IDX_ADDR(IDX_ADDR),
        .DAT_ADDR(DAT_ADDR),
        .CTRL_IDX(CTRL_IDX)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_wdata(io_wdata),
        .io_rdata(io_rdata),
        .ctrl    (ctrl_q)
    );

    fpb_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .hblank   (hblank),
        .vblank   (vblank),
        .lp_strobe(lp_strobe),
        .keep_vb  (ctrl_q.de_hb_only | ctrl_q.vb_lp_keep),
        .de       (panel_de),
        .lp       (panel_lp)
    );

    fpb_fmt u_fmt (
        .clk     (clk),
        .rst     (rst),
        .wid     (ctrl_q.wid),
        .force_hi(ctrl_q.vb_force_hi),
        .hblank  (hblank),
        .vblank  (vblank),
        .pix     (pix),
        .data    (panel_data)
    );
endmodule

// File: rtl/fpb_checker.sv
`timescale 1ns/1ps
module fpb_checker
    import fpb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hblank,
    input logic             vblank,
    input logic             lp_strobe,
    input logic [REG_W-1:0] ctrl,
    input logic [BUS_W-1:0] panel_data,
    input logic             panel_de,
    input logic             panel_lp
);
    logic past_valid;
    logic keep;

    assign keep = ctrl[4] | ctrl[3];

    always_ff @(posedge clk) begin
        if (rst) past_valid <= 1'b0;
        else     past_valid <= 1'b1;
    end

    // R9: both blanks gate the enable when neither keep bit is set
    p_de_vb_off_r9: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(vblank) && !$past(keep)) |-> !panel_de);

    // R10: horizontal blank always removes the enable
    p_de_hb_off_r10: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(hblank)) |-> !panel_de);

    // R12: no line pulse in vertical blank without a keep bit
    p_lp_vb_off_r12: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(vblank) && !$past(keep)) |-> !panel_lp);

    // R7: forced-high data during vertical blank
    p_force_high_r7: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(vblank) && $past(ctrl[5])) |-> (&panel_data));

    // R3: upper bus lines idle in 16-bit mode
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(ctrl[7:6] == 2'b00) && !$past(vblank && ctrl[5]))
        |-> (panel_data[BUS_W-1:16] == '0));

    // R13: enable follows active video one clock later
    p_de_on_r13: assert property (@(posedge clk) disable iff (rst)
        (past_valid && $past(!hblank && !vblank)) |-> panel_de);

    // R13: line pulse never appears without a strobe the clock before
    p_lp_src_r13: assert property (@(posedge clk) disable iff (rst)
        (past_valid && !$past(lp_strobe)) |-> !panel_lp);
endmodule

bind fp_blank_ctrl fpb_checker u_fpb_checker (
    .clk       (clk),
    .rst       (rst),
    .hblank    (hblank),
    .vblank    (vblank),
    .lp_strobe (lp_strobe),
    .ctrl      (ctrl_q),
    .panel_data(panel_data),
    .panel_de  (panel_de),
    .panel_lp  (panel_lp)
);

// File: tb/tb_fp_blank_ctrl.sv
`timescale 1ns/1ps
module tb_fp_blank_ctrl;
    localparam logic [15:0] IDX = 16'h03D0;
    localparam logic [15:0] DAT = 16'h03D1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        hblank = 1'b0, vblank = 1'b0, lp_strobe = 1'b0;
    logic [7:0]  pix_r = 8'hA5, pix_g = 8'h3C, pix_b = 8'hF0;
    logic [35:0] panel_data;
    logic        panel_de, panel_lp;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fp_blank_ctrl dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hblank(hblank),
        .vblank(vblank), .lp_strobe(lp_strobe), .pix_r(pix_r),
        .pix_g(pix_g), .pix_b(pix_b), .panel_data(panel_data),
        .panel_de(panel_de), .panel_lp(panel_lp)
    );

    typedef struct packed {
        logic [7:0]  c;
        logic        hb, vb, lp;
        logic [35:0] d;
        logic        de, lpo;
    } vec_t;

    // pixel A5/3C/F0: 565 word A1FEh, 888 word A53CF0h
    localparam vec_t VEC [11] = '{
        '{8'h00, 1'b0, 1'b0, 1'b0, 36'h00000A1FE, 1'b1, 1'b0},  // R3 R9
        '{8'h40, 1'b0, 1'b0, 1'b1, 36'h000A53CF0, 1'b1, 1'b1},  // R4
        '{8'h80, 1'b0, 1'b0, 1'b0, 36'h00000A1FE, 1'b1, 1'b0},  // R5
        '{8'h00, 1'b1, 1'b0, 1'b1, 36'h00000A1FE, 1'b0, 1'b1},  // R9
        '{8'h00, 1'b0, 1'b1, 1'b1, 36'h00000A1FE, 1'b0, 1'b0},  // R8 R12
        '{8'h20, 1'b0, 1'b1, 1'b1, 36'hFFFFFFFFF, 1'b0, 1'b0},  // R7
        '{8'h20, 1'b0, 1'b0, 1'b0, 36'h00000A1FE, 1'b1, 1'b0},  // R7 outside vb
        '{8'h08, 1'b0, 1'b1, 1'b1, 36'h00000A1FE, 1'b1, 1'b1},  // R10
        '{8'h08, 1'b1, 1'b1, 1'b0, 36'h00000A1FE, 1'b0, 1'b0},  // R10
        '{8'h10, 1'b0, 1'b1, 1'b1, 36'h00000A1FE, 1'b1, 1'b1},  // R11
        '{8'h60, 1'b0, 1'b1, 1'b0, 36'hFFFFFFFFF, 1'b0, 1'b0}   // R7 R4
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        step();
        io_wr = 1'b0;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        wr(IDX, 8'h12);
        wr(DAT, v);
    endtask

    task automatic rd_ctrl(output logic [7:0] v);
        io_addr = IDX; io_wdata = 8'h12; io_wr = 1'b1;
        step();
        io_wr = 1'b0; io_addr = DAT;
        #1;
        v = io_rdata;
    endtask

    task automatic frame(input logic [7:0] c, input int exp_n, input string req);
        int cnt = 0;
        set_ctrl(c);
        for (int line = 0; line < 262; line++) begin
            vblank = (line >= 240);
            for (int k = 0; k < 10; k++) begin
                hblank = (k < 4);
                lp_strobe = (k == 1);
                step();
                if (panel_lp) cnt++;
            end
        end
        hblank = 1'b0; vblank = 1'b0; lp_strobe = 1'b0;
        step();
        if (panel_lp) cnt++;
        chk(req, 36'(cnt), 36'(exp_n));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  rv;
        logic [17:0] a18, b18;
        logic [35:0] word;

        // reset state (R13, R1)
        hblank = 1'b1; lp_strobe = 1'b1;
        repeat (3) step();
        chk("R13 reset data", panel_data, 36'h0);
        chk("R13 reset de", 36'(panel_de), 36'h0);
        chk("R13 reset lp", 36'(panel_lp), 36'h0);
        rst = 1'b0;
        lp_strobe = 1'b0;
        rd_ctrl(rv);
        chk("R1 reset readback", 36'(rv), 36'h00);

        // vector table
        foreach (VEC[i]) begin
            set_ctrl(VEC[i].c);
            hblank = VEC[i].hb; vblank = VEC[i].vb; lp_strobe = VEC[i].lp;
            step();
            chk($sformatf("R3-table vec%0d data", i), panel_data, VEC[i].d);
            chk($sformatf("R9-table vec%0d de", i), 36'(panel_de), 36'(VEC[i].de));
            chk($sformatf("R12-table vec%0d lp", i), 36'(panel_lp), 36'(VEC[i].lpo));
            hblank = 1'b0; vblank = 1'b0; lp_strobe = 1'b0;
        end

        // R1 readback of written value including spare bits
        set_ctrl(8'h5B);
        rd_ctrl(rv);
        chk("R1 readback", 36'(rv), 36'h5B);

        // R2 write with another index selected
        wr(IDX, 8'h11);
        wr(DAT, 8'hFF);
        rd_ctrl(rv);
        chk("R2 other index ignored", 36'(rv), 36'h5B);

        // R6 36-bit pairing
        set_ctrl(8'hC0);
        hblank = 1'b1;
        step();
        step();
        hblank = 1'b0;
        pix_r = 8'hA5; pix_g = 8'h3C; pix_b = 8'hF0;
        a18 = {pix_r[7:2], pix_g[7:2], pix_b[7:2]};
        step();
        pix_r = 8'h11; pix_g = 8'h22; pix_b = 8'h33;
        b18 = {pix_r[7:2], pix_g[7:2], pix_b[7:2]};
        step();
        chk("R6 pair word", panel_data, {b18, a18});
        word = panel_data;
        pix_r = 8'h77; pix_g = 8'h88; pix_b = 8'h99;
        step();
        chk("R6 hold on first of pair", panel_data, word);
        pix_r = 8'hFF; pix_g = 8'h00; pix_b = 8'hFF;
        step();
        chk("R6 second pair", panel_data,
            {6'h3F, 6'h00, 6'h3F, 6'(8'h77 >> 2), 6'(8'h88 >> 2), 6'(8'h99 >> 2)});
        pix_r = 8'hA5; pix_g = 8'h3C; pix_b = 8'hF0;

        // R13 one-clock latency
        set_ctrl(8'h00);
        hblank = 1'b1;
        step();
        chk("R13 de low in blank", 36'(panel_de), 36'h0);
        hblank = 1'b0;
        #1;
        chk("R13 de not early", 36'(panel_de), 36'h0);
        step();
        chk("R13 de after one clock", 36'(panel_de), 36'h1);

        // R12 dual-drive frame, R10 and R11 keep-alive frames
        frame(8'h00, 240, "R12 frame pulses");
        frame(8'h08, 262, "R10 frame pulses");
        frame(8'h10, 262, "R11 frame pulses");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule